// File: doc/BRIEF.md
# ISA host address window decoder

This block sits on the host side of a network adapter attached to an ISA bus and decides, cycle by cycle, whether the current host cycle is meant for the adapter. It keeps two one-byte configuration registers. The first sets the I/O base. The second places a buffer RAM window in the memory map. Both registers are written and read back over a small register port.

For I/O cycles, a split set of host address lines is compared with the programmed I/O base. The match is qualified by the I/O strobes and by the DMA address-enable line. For memory cycles, the block checks whether the host address lies inside a window. The window is set by a base, an encoded size and an option that places it either in the first megabyte or in the sixteenth.

Both decoders stay quiet after reset until an activate input is seen. A boot flag in the I/O base register lets decoding start at once, without waiting for that input.

Top module: `isa_win_decode`

## Requirements
- R1: After reset the I/O base register reads 0x08, the RAM register reads 0x04 and the activate latch is clear.
- R2: A write with `reg_sel`=0 loads the I/O base register and a write with `reg_sel`=1 loads the RAM register. The new value is visible on the clock edge after the write strobe, and `reg_rdata` returns the selected byte exactly as stored.
- R3: `io_sel` is 0 unless `host_ior` or `host_iow` is 1 and `host_aen` is 0.
- R4: `io_sel` needs I/O base bits 7..5 to equal `host_addr[15:13]` and bits 4..1 to equal `host_addr[8:5]`. No other address line has any effect.
- R5: Decoding is enabled when I/O base bit 0 (boot flag) is 1 or the activate latch is set. A 1 on `pnp_activate` sets the latch from the next edge, and only reset clears it. While decoding is disabled, `io_sel` and `mem_sel` are 0.
- R6: The window base over address bits 19..13 is {1,1, RAM bit 6, RAM bits 3..0}. Size code RAM[5:4] 00/01/10/11 gives 8/16/32/64 KB. Memory matches when bits 19..13 are at or above the base and below base plus size.
- R7: The upper window limit does not wrap past address bit 19. A window that would overflow ends at the top of its 1 MB region.
- R8: When RAM bit 7 is 0, `host_addr[23:20]` must be 0x0 for a memory match. When it is 1, they must be 0xF.
- R9: `mem_sel` is 0 unless `host_memr` or `host_memw` is 1. It drops in the same cycle the address leaves the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects I/O base register, 1 selects RAM register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pnp_activate | input | 1 | Activate request; sets the enable latch |
| host_addr | input | 24 | Host address lines 23..0 |
| host_ior | input | 1 | I/O read strobe, active high |
| host_iow | input | 1 | I/O write strobe, active high |
| host_aen | input | 1 | DMA address enable, active high |
| host_memr | input | 1 | Memory read strobe, active high |
| host_memw | input | 1 | Memory write strobe, active high |
| io_sel | output | 1 | I/O cycle addressed to the adapter |
| mem_sel | output | 1 | Memory cycle inside the RAM window |

## Verification
Directed I/O cycles flip one compared address line at a time and toggle lines outside the compare. This shows whether each of the seven base bits is wired to the right host line. Memory addresses are placed one 8 KB block below the base, at the base, at the last byte and one block past the end. This separates an off-by-one at either edge from a wrong size decode. A 64 KB window based near the top of the megabyte exposes any wrap-around of the limit. That window is probed with both top-nibble values, which tells the high-RAM option apart from a plain range check. A boot-flag run after a fresh reset, without activation, shows whether the enable is taken from the boot flag or only from the latch. A long pseudo-random phase then mixes writes, activation and bus cycles against the bench model.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic [BYTE_W-1:0] io_base;
        logic [BYTE_W-1:0] ram_cfg;
        logic              act;
    } cfg_state_t;

    localparam int BLK_W = 7;   // address bits 19..13, 8 KB granularity
    localparam logic [1:0] WIN_TOP_FIXED = 2'b11;
endpackage

// File: rtl/isa_win_regs.sv
module isa_win_regs
    import isa_win_pkg::*;
#(
    parameter logic [BYTE_W-1:0] IO_RST  = 8'h08,
    parameter logic [BYTE_W-1:0] RAM_RST = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              activate,
    output logic [BYTE_W-1:0] io_base,
    output logic [BYTE_W-1:0] ram_cfg,
    output logic              act,
    output logic [BYTE_W-1:0] rdata
);
    localparam cfg_state_t RST_STATE = '{io_base: IO_RST, ram_cfg: RAM_RST, act: 1'b0};

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (sel) st_d.ram_cfg = wdata;
            else     st_d.io_base = wdata;
        end
        if (activate) st_d.act = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign io_base = st_q.io_base;
    assign ram_cfg = st_q.ram_cfg;
    assign act     = st_q.act;
    assign rdata   = sel ? st_q.ram_cfg : st_q.io_base;

    assert_io_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> io_base == $past(wdata));
    assert_ram_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel) |=> ram_cfg == $past(wdata));
    assert_act_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> act);
endmodule

// File: rtl/isa_io_match.sv
module isa_io_match #(
    parameter int HI_W = 3,
    parameter int LO_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [HI_W-1:0] base_hi,
    input  logic [LO_W-1:0] base_lo,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [LO_W-1:0] addr_lo,
    input  logic            ior,
    input  logic            iow,
    input  logic            aen,
    output logic            io_sel
);
    localparam int NBITS = HI_W + LO_W;

    logic [NBITS-1:0] bit_eq;

    for (genvar i = 0; i < NBITS; i++) begin : g_cmp
        if (i < LO_W) begin : g_lo
            assign bit_eq[i] = (addr_lo[i] == base_lo[i]);
        end else begin : g_hi
            assign bit_eq[i] = (addr_hi[i-LO_W] == base_hi[i-LO_W]);
        end
    end

    always_comb begin
        io_sel = en && (ior || iow) && !aen && (&bit_eq);
    end

    assert_io_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> ((ior || iow) && !aen));
    assert_io_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel |-> (addr_hi == base_hi && addr_lo == base_lo));
endmodule

// File: rtl/isa_mem_match.sv
module isa_mem_match
    import isa_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] ram_cfg,
    input  logic [3:0]        addr_top,
    input  logic [BLK_W-1:0]  addr_blk,
    input  logic              memr,
    input  logic              memw,
    output logic              mem_sel
);
    logic [BLK_W-1:0] base_blk;
    logic [BLK_W:0]   span, limit;
    logic             above, below, top_ok;

    always_comb begin
        base_blk = {WIN_TOP_FIXED, ram_cfg[6], ram_cfg[3:0]};
        span     = (BLK_W+1)'(1) << ram_cfg[5:4];
        limit    = {1'b0, base_blk} + span;   // one extra bit: no wrap
        above    = addr_blk >= base_blk;
        below    = {1'b0, addr_blk} < limit;
        top_ok   = ram_cfg[7] ? (addr_top == 4'hF) : (addr_top == 4'h0);
        mem_sel  = en && (memr || memw) && above && below && top_ok;
    end

    assert_mem_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (memr || memw));
    assert_mem_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (addr_top == {4{ram_cfg[7]}}));
    assert_mem_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sel |-> (addr_blk[6:5] == 2'b11));
endmodule

// File: rtl/isa_win_decode.sv
module isa_win_decode
    import isa_win_pkg::*;
#(
    parameter int              ADDR_W  = 24,
    parameter logic [7:0]      IO_RST  = 8'h08,
    parameter logic [7:0]      RAM_RST = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              pnp_activate,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_ior,
    input  logic              host_iow,
    input  logic              host_aen,
    input  logic              host_memr,
    input  logic              host_memw,
    output logic              io_sel,
    output logic              mem_sel
);
    logic [7:0] io_base, ram_cfg;
    logic       act, dec_en;
    logic       unused_addr;

    assign unused_addr = ^{host_addr[12:9], host_addr[4:0]};

    isa_win_regs #(.IO_RST(IO_RST), .RAM_RST(RAM_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .activate(pnp_activate), .io_base(io_base), .ram_cfg(ram_cfg),
        .act(act), .rdata(reg_rdata)
    );

    assign dec_en = io_base[0] | act;

    isa_io_match #(.HI_W(3), .LO_W(4)) u_io (
        .clk(clk), .rst_n(rst_n), .en(dec_en),
        .base_hi(io_base[7:5]), .base_lo(io_base[4:1]),
        .addr_hi(host_addr[15:13]), .addr_lo(host_addr[8:5]),
        .ior(host_ior), .iow(host_iow), .aen(host_aen), .io_sel(io_sel)
    );

    isa_mem_match u_mem (
        .clk(clk), .rst_n(rst_n), .en(dec_en), .ram_cfg(ram_cfg),
        .addr_top(host_addr[23:20]), .addr_blk(host_addr[19:13]),
        .memr(host_memr), .memw(host_memw), .mem_sel(mem_sel)
    );

    assert_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel || mem_sel) |-> (io_base[0] || act));
endmodule

// File: tb/isa_win_decode_tb.sv
module isa_win_decode_tb_top;
    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_sel = 0, pnp_activate = 0;
    logic [7:0]  reg_wdata = 0, reg_rdata;
    logic [23:0] host_addr = 0;
    logic        host_ior = 0, host_iow = 0, host_aen = 0, host_memr = 0, host_memw = 0;
    logic        io_sel, mem_sel;

    int checks = 0, errors = 0;
    int m_io, m_ram, m_act;

    always #10 clk = ~clk;

    isa_win_decode dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pnp_activate(pnp_activate),
        .host_addr(host_addr), .host_ior(host_ior), .host_iow(host_iow),
        .host_aen(host_aen), .host_memr(host_memr), .host_memw(host_memw),
        .io_sel(io_sel), .mem_sel(mem_sel)
    );

    function automatic int exp_io();
        int a = int'(host_addr);
        int en = ((m_io & 1) != 0 || m_act != 0) ? 1 : 0;
        int hi_ok = (((a >> 13) & 7) == ((m_io >> 5) & 7)) ? 1 : 0;
        int lo_ok = (((a >> 5) & 15) == ((m_io >> 1) & 15)) ? 1 : 0;
        return (en && (host_ior || host_iow) && !host_aen && hi_ok && lo_ok) ? 1 : 0;
    endfunction

    function automatic int exp_mem();
        int a = int'(host_addr);
        int en = ((m_io & 1) != 0 || m_act != 0) ? 1 : 0;
        int base = 'hC0000 + (((m_ram >> 6) & 1) << 17) + ((m_ram & 15) << 13);
        int size = 8192 << ((m_ram >> 4) & 3);
        int low = a & 'hFFFFF;
        int want_top = ((m_ram >> 7) & 1) ? 15 : 0;
        int in_win = (low >= base && low < base + size) ? 1 : 0;
        return (en && (host_memr || host_memw) && in_win && ((a >> 20) & 15) == want_top) ? 1 : 0;
    endfunction

    task automatic check(string tag, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // Inputs are set at a falling edge; outputs are compared 5 ns later,
    // then the model takes the rising edge.
    task automatic step(string tag);
        #5;
        check({tag, " io_sel"}, int'(io_sel), exp_io());
        check({tag, " mem_sel"}, int'(mem_sel), exp_mem());
        check("R2 rdata", int'(reg_rdata), reg_sel ? m_ram : m_io);
        @(posedge clk);
        if (reg_wr) begin
            if (reg_sel) m_ram = int'(reg_wdata);
            else         m_io  = int'(reg_wdata);
        end
        if (pnp_activate) m_act = 1;
        @(negedge clk);
    endtask

    task automatic bus(logic [23:0] a, logic ior, logic iow, logic aen, logic mr, logic mw);
        host_addr = a; host_ior = ior; host_iow = iow; host_aen = aen;
        host_memr = mr; host_memw = mw;
    endtask

    task automatic wreg(logic sel, logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1;
        step("R2 write");
        reg_wr = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        m_io = 'h08; m_ram = 'h04; m_act = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset values
        reg_sel = 0; #1; check("R1 io reset", int'(reg_rdata), 'h08);
        reg_sel = 1; #1; check("R1 ram reset", int'(reg_rdata), 'h04);
        reg_sel = 0;
        // R5: not yet enabled, matching cycles must stay silent
        bus(24'h000080, 1, 0, 0, 0, 0); step("R5 disabled io");
        bus(24'h0C8000, 0, 0, 0, 1, 0); step("R5 disabled mem");
        pnp_activate = 1; bus(24'h0, 0, 0, 0, 0, 0); step("R5 activate");
        pnp_activate = 0;
        bus(24'h000080, 1, 0, 0, 0, 0); step("R5 enabled io");
        // R3 qualification
        bus(24'h000080, 1, 0, 1, 0, 0); step("R3 aen");
        bus(24'h000080, 0, 0, 0, 0, 0); step("R3 no strobe");
        bus(24'h000080, 0, 1, 0, 0, 0); step("R3 iow");
        // R4 per-bit compare and ignored lines
        for (int b = 0; b < 16; b++) begin
            bus(24'h000080 ^ (24'h1 << b), 1, 0, 0, 0, 0); step("R4 bit flip");
        end
        bus(24'hFF1E9F, 1, 0, 0, 0, 0); step("R4 ignored lines");
        // R6 default window 0xC8000..0xC9FFF
        bus(24'h0C7FFF, 0, 0, 0, 1, 0); step("R6 below");
        bus(24'h0C8000, 0, 0, 0, 1, 0); step("R6 base");
        bus(24'h0C9FFF, 0, 0, 0, 0, 1); step("R6 last");
        bus(24'h0CA000, 0, 0, 0, 1, 0); step("R6 past");
        bus(24'h0C8000, 0, 0, 0, 0, 0); step("R9 no strobe");
        bus(24'h1C8000, 0, 0, 0, 1, 0); step("R8 top nonzero");
        // R6 sizes
        for (int s = 0; s < 4; s++) begin
            wreg(1, 8'(s << 4) | 8'h02);
            bus(24'h0C4000 + 24'((8192 << s) - 1), 0, 0, 0, 1, 0); step("R6 size last");
            bus(24'h0C4000 + 24'(8192 << s), 0, 0, 0, 1, 0); step("R6 size past");
        end
        // R7/R8: 64 KB window at 0xFE000 with high RAM
        wreg(1, 8'hFF);
        bus(24'hFFE000, 0, 0, 0, 1, 0); step("R7 base high");
        bus(24'hFFFFFF, 0, 0, 0, 1, 0); step("R7 top clip");
        bus(24'hF00000, 0, 0, 0, 1, 0); step("R7 no wrap");
        bus(24'hFFDFFF, 0, 0, 0, 1, 0); step("R7 below");
        bus(24'h0FE000, 0, 0, 0, 1, 0); step("R8 hram low nibble");
        // R9 deassert as address leaves window
        bus(24'hFFE000, 0, 0, 0, 1, 0); step("R9 inside");
        bus(24'hFFC000, 0, 0, 0, 1, 0); step("R9 left");
        // R5 boot flag after fresh reset, no activation
        do_reset();
        bus(24'h00E000, 1, 0, 0, 0, 0); step("R5 pre boot");
        wreg(0, 8'hE1);
        reg_sel = 0; #1; check("R2 readback", int'(reg_rdata), 'hE1);
        bus(24'h00E000, 1, 0, 0, 0, 0); step("R5 boot io");
        bus(24'h0C8000, 0, 0, 0, 1, 0); step("R5 boot mem");
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [23:0] a = 24'($urandom);
            if ($urandom_range(1, 0) == 1) a[19:18] = 2'b11;
            if ($urandom_range(1, 0) == 1) a[23:20] = m_ram[7] ? 4'hF : 4'h0;
            if ($urandom_range(3, 0) == 0) begin
                a[15:13] = 3'(m_io >> 5); a[8:5] = 4'(m_io >> 1);
            end
            bus(a, 1'($urandom), 1'($urandom), ($urandom_range(3, 0) == 0),
                1'($urandom), 1'($urandom));
            reg_sel = 1'($urandom);
            reg_wr = ($urandom_range(7, 0) == 0);
            reg_wdata = 8'($urandom);
            pnp_activate = ($urandom_range(31, 0) == 0);
            step("R4 R6 random");
        end
        reg_wr = 0; pnp_activate = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule